// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous host and an external asynchronous static RAM of 131,072 bytes. The host issues one word at a time on a valid/ready port: a write carrying an address and a byte, or a read that returns one byte on a one-cycle response strobe. The controller turns each request into a timed pin sequence. It drives a 17-bit address, a select pair made of an active-low enable and an active-high enable, an active-low output enable, an active-low write enable, and a data bus that is split into out, out-enable and in.

Each phase of a pin sequence is held for a whole number of clock cycles. That number is the required time in nanoseconds divided by the clock-period parameter (in picoseconds), rounded up, with a minimum of one cycle. After reset the controller waits out a power-up interval before it accepts any request. Between accesses it deselects the RAM so that the RAM can drop into its low-power state. During a write, output enable stays high. After a read, the controller keeps off the data bus until the RAM has had time to release it.

Top module: `sram_seq_ctrl`

## Requirements
- R1: From reset, `req_ready` is 0 and the RAM is deselected (`sram_cs_n`=1, `sram_cs`=0, `sram_we_n`=1). `req_ready` first reads 1 after exactly PWR clock edges, where PWR = max(1, ceil(T_PWRUP_NS*1000/CLK_PERIOD_PS)).
- R2: Whenever `req_ready` is 1, the pins are idle: `sram_cs_n`=1, `sram_cs`=0, `sram_oe_n`=1, `sram_we_n`=1 and `sram_dq_oe`=0.
- R3: A request is taken only at a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 in the cycle after that edge and stays 0 until the access has finished. A request held valid during the power-up wait starts no write.
- R4: A read (`req_write`=0) holds `sram_cs_n`=0, `sram_cs`=1, `sram_oe_n`=0, `sram_we_n`=1, `sram_dq_oe`=0 and the accepted address for RD = max(1, ceil(max(T_RD_CYCLE_NS, T_ADDR_VALID_NS)*1000/CLK_PERIOD_PS)) cycles.
- R5: The read byte is sampled from `sram_dq_in` at the edge that ends the last read cycle. It is presented on `rsp_rdata` with `rsp_valid`=1 for exactly the one following cycle.
- R6: After a read, the controller runs HZ = max(1, ceil(T_OE_FLOAT_NS*1000/CLK_PERIOD_PS)) further cycles with `sram_oe_n`=1, `sram_dq_oe`=0 and `req_ready`=0. The data bus is never driven until at least HZ cycles have passed with `sram_oe_n` high.
- R7: A write (`req_write`=1) holds `sram_we_n`=0 for WP = max(1, ceil(max(T_WE_PULSE_NS, T_DATA_SETUP_NS, T_ADDR_SETUP_NS)*1000/CLK_PERIOD_PS)) cycles. It then holds `sram_we_n`=1 for WR = max(1, ceil(T_WR_CYCLE_NS*1000/CLK_PERIOD_PS) - WP) cycles. Throughout both parts the RAM stays selected, `sram_oe_n`=1, `sram_dq_oe`=1 and the byte is driven.
- R8: With a 4000 ps clock and the default times, the phase lengths are RD=3, HZ=2, WP=2 and WR=1. A read keeps `req_ready` low for 5 cycles and a write keeps it low for 3 cycles.
- R9: Address and write data are captured at acceptance. Changes on `req_addr` and `req_wdata` during an access do not reach `sram_addr` or `sram_dq_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write byte |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DATA_W | Read byte |
| sram_addr | output | ADDR_W | RAM address pins |
| sram_cs_n | output | 1 | Active-low select |
| sram_cs | output | 1 | Active-high select |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_we_n | output | 1 | Active-low write enable |
| sram_dq_out | output | DATA_W | Data driven toward the RAM |
| sram_dq_oe | output | 1 | Data bus drive enable |
| sram_dq_in | input | DATA_W | Data returned by the RAM |

## Verification
The bench writes and then reads back a sweep of addresses. The sweep covers address zero, all ones, and every single-bit address across the 17 lines, each with a byte computed from its address. A missing, swapped or stuck address bit therefore shows up as a wrong byte on read-back. The bench's RAM model only presents valid data from the third read cycle onward, so sampling one cycle too early returns a poison byte. Back-to-back write/read pairs and host fields that change during an access separate correct turnaround and capture-at-accept from a design that drives early or passes requests through. A request held during the power-up wait checks that the wait gates acceptance.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_READ  = 3'd1,
      PH_TURN  = 3'd2,
      PH_WRITE = 3'd3,
      PH_WREC  = 3'd4
   } phase_e;

   // required ns -> whole clock cycles, rounded up, never below one
   function automatic int ns_to_cyc(input int ns, input int per_ps);
      int c;
      c = (ns * 1000 + per_ps - 1) / per_ps;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_pwrup_wait.sv
module sram_pwrup_wait #(
   parameter int CYC = 25000
) (
   input  logic clk,
   input  logic rst_n,
   output logic done
);
   if (CYC < 1) begin : g_bad_cyc
      $error("sram_pwrup_wait: CYC must be at least 1");
   end

   generate
      if (CYC == 1) begin : g_single
         logic done_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) done_q <= 1'b0;
            else        done_q <= 1'b1;
         end
         assign done = done_q;
      end else begin : g_count
         localparam int CW = $clog2(CYC + 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  cnt <= '0;
            else if (cnt != CW'(CYC))    cnt <= cnt + 1'b1;
         end
         assign done = (cnt == CW'(CYC));
      end
   endgenerate

endmodule

// File: rtl/sram_phase_cnt.sv
module sram_phase_cnt #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);
   if (W < 1) begin : g_bad_w
      $error("sram_phase_cnt: W must be at least 1");
   end

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (load)        cnt <= load_val;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
   import sram_seq_pkg::*;
#(
   parameter int ADDR_W          = 17,
   parameter int DATA_W          = 8,
   parameter int CLK_PERIOD_PS   = 4000,
   parameter int T_RD_CYCLE_NS   = 10,
   parameter int T_ADDR_VALID_NS = 10,
   parameter int T_OE_FLOAT_NS   = 5,
   parameter int T_WR_CYCLE_NS   = 10,
   parameter int T_WE_PULSE_NS   = 7,
   parameter int T_DATA_SETUP_NS = 6,
   parameter int T_ADDR_SETUP_NS = 7,
   parameter int T_PWRUP_NS      = 100000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] sram_addr,
   output logic              sram_cs_n,
   output logic              sram_cs,
   output logic              sram_oe_n,
   output logic              sram_we_n,
   output logic [DATA_W-1:0] sram_dq_out,
   output logic              sram_dq_oe,
   input  logic [DATA_W-1:0] sram_dq_in
);
   localparam int RD_CYC  = ns_to_cyc(imax(T_RD_CYCLE_NS, T_ADDR_VALID_NS), CLK_PERIOD_PS);
   localparam int HZ_CYC  = ns_to_cyc(T_OE_FLOAT_NS, CLK_PERIOD_PS);
   localparam int WP_CYC  = ns_to_cyc(imax(T_WE_PULSE_NS, imax(T_DATA_SETUP_NS, T_ADDR_SETUP_NS)),
                                      CLK_PERIOD_PS);
   localparam int WC_CYC  = ns_to_cyc(T_WR_CYCLE_NS, CLK_PERIOD_PS);
   localparam int WR_CYC  = imax(1, WC_CYC - WP_CYC);
   localparam int PWR_CYC = ns_to_cyc(T_PWRUP_NS, CLK_PERIOD_PS);
   localparam int MAX_CYC = imax(imax(RD_CYC, HZ_CYC), imax(WP_CYC, WR_CYC));
   localparam int PH_W    = $clog2(MAX_CYC + 1);

   if (CLK_PERIOD_PS < 1) begin : g_bad_period
      $error("sram_seq_ctrl: CLK_PERIOD_PS must be positive");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("sram_seq_ctrl: ADDR_W and DATA_W must be positive");
   end

   phase_e            state;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdata_q;
   logic              rsp_q;
   logic              pw_done;
   logic              ph_load;
   logic [PH_W-1:0]   ph_val;
   logic              ph_zero;
   logic              accept;

   sram_pwrup_wait #(.CYC(PWR_CYC)) u_pwrup (
      .clk   (clk),
      .rst_n (rst_n),
      .done  (pw_done)
   );

   sram_phase_cnt #(.W(PH_W)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ph_load),
      .load_val (ph_val),
      .zero     (ph_zero)
   );

   assign req_ready = pw_done && (state == PH_IDLE);
   assign accept    = req_valid && req_ready;

   always_comb begin
      ph_load = 1'b0;
      ph_val  = '0;
      unique case (state)
         PH_IDLE: if (accept) begin
            ph_load = 1'b1;
            ph_val  = req_write ? PH_W'(WP_CYC - 1) : PH_W'(RD_CYC - 1);
         end
         PH_READ: if (ph_zero) begin
            ph_load = 1'b1;
            ph_val  = PH_W'(HZ_CYC - 1);
         end
         PH_WRITE: if (ph_zero) begin
            ph_load = 1'b1;
            ph_val  = PH_W'(WR_CYC - 1);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= PH_IDLE;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         rsp_q   <= 1'b0;
      end else begin
         rsp_q <= 1'b0;
         unique case (state)
            PH_IDLE: if (accept) begin
               addr_q  <= req_addr;
               wdata_q <= req_wdata;
               state   <= req_write ? PH_WRITE : PH_READ;
            end
            PH_READ: if (ph_zero) begin
               rdata_q <= sram_dq_in;
               rsp_q   <= 1'b1;
               state   <= PH_TURN;
            end
            PH_TURN:  if (ph_zero) state <= PH_IDLE;
            PH_WRITE: if (ph_zero) state <= PH_WREC;
            PH_WREC:  if (ph_zero) state <= PH_IDLE;
            default:  state <= PH_IDLE;
         endcase
      end
   end

   always_comb begin
      sram_cs_n  = 1'b1;
      sram_cs    = 1'b0;
      sram_oe_n  = 1'b1;
      sram_we_n  = 1'b1;
      sram_dq_oe = 1'b0;
      unique case (state)
         PH_READ: begin
            sram_cs_n = 1'b0;
            sram_cs   = 1'b1;
            sram_oe_n = 1'b0;
         end
         PH_WRITE: begin
            sram_cs_n  = 1'b0;
            sram_cs    = 1'b1;
            sram_we_n  = 1'b0;
            sram_dq_oe = 1'b1;
         end
         PH_WREC: begin
            sram_cs_n  = 1'b0;
            sram_cs    = 1'b1;
            sram_dq_oe = 1'b1;
         end
         default: ;
      endcase
   end

   assign sram_addr   = addr_q;
   assign sram_dq_out = wdata_q;
   assign rsp_valid   = rsp_q;
   assign rsp_rdata   = rdata_q;

   // ---- timing monitors watching the pins ----
   logic [7:0] we_low_cnt;
   logic [7:0] oe_quiet_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_low_cnt   <= '0;
         oe_quiet_cnt <= 8'hFF;
      end else begin
         if (!sram_we_n) begin
            if (we_low_cnt != 8'hFF) we_low_cnt <= we_low_cnt + 8'd1;
         end else begin
            we_low_cnt <= '0;
         end
         if (!sram_oe_n) oe_quiet_cnt <= '0;
         else if (oe_quiet_cnt != 8'hFF) oe_quiet_cnt <= oe_quiet_cnt + 8'd1;
      end
   end

   AST_BOOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !pw_done |-> (!req_ready && sram_cs_n && sram_we_n)); // R1
   AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (sram_cs_n && !sram_cs && sram_oe_n && sram_we_n && !sram_dq_oe)); // R2
   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready); // R3
   AST_RD_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_oe_n && $past(!sram_oe_n)) |-> $stable(sram_addr)); // R4
   AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R5
   AST_BUS_TURN: assert property (@(posedge clk) disable iff (!rst_n)
      sram_dq_oe |-> (int'(oe_quiet_cnt) >= HZ_CYC)); // R6
   AST_WE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> (sram_oe_n && sram_dq_oe && !sram_cs_n && sram_cs)); // R7
   AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_we_n) |-> (int'(we_low_cnt) >= WP_CYC)); // R7

endmodule

// File: tb/test_sram_seq_ctrl.sv
`timescale 1ns/1ps
module test_sram_seq_ctrl;
   localparam int AW     = 17;
   localparam int DW     = 8;
   localparam int PER_PS = 4000;
   localparam int PWR_NS = 400;

   function automatic int cyc(input int ns);
      int c;
      c = (ns * 1000 + PER_PS - 1) / PER_PS;
      return (c < 1) ? 1 : c;
   endfunction

   localparam int E_PWR = cyc(PWR_NS);   // 100
   localparam int E_RD  = cyc(10);       // 3
   localparam int E_HZ  = cyc(5);        // 2
   localparam int E_WP  = cyc(7);        // 2
   localparam int E_WR  = (cyc(10) - E_WP < 1) ? 1 : cyc(10) - E_WP; // 1

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic req_ready, rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic [AW-1:0] sram_addr;
   logic sram_cs_n, sram_cs, sram_oe_n, sram_we_n, sram_dq_oe;
   logic [DW-1:0] sram_dq_out, sram_dq_in;

   int checks = 0;
   int fails = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   sram_seq_ctrl #(.T_PWRUP_NS(PWR_NS)) i_sram_seq_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .sram_addr(sram_addr), .sram_cs_n(sram_cs_n), .sram_cs(sram_cs),
      .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
      .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
   );

   // RAM model: valid read data only from the third selected read cycle on
   logic [DW-1:0] mem [int unsigned];
   int rd_cnt = 0;
   wire rd_cond = !sram_cs_n && sram_cs && !sram_oe_n && sram_we_n;

   always @(posedge clk) begin
      if (!sram_cs_n && sram_cs && !sram_we_n && sram_dq_oe)
         mem[int'(sram_addr)] = sram_dq_out;
      rd_cnt <= rd_cond ? rd_cnt + 1 : 0;
   end

   always_comb begin
      if (rd_cond && rd_cnt >= 2 && mem.exists(int'(sram_addr)))
         sram_dq_in = mem[int'(sram_addr)];
      else
         sram_dq_in = 8'hEE;
   end

   function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
      return a[7:0] ^ a[15:8] ^ {a[16], 7'h35};
   endfunction

   function automatic logic [AW-1:0] sweep_addr(input int i);
      if (i == 0)  return '0;
      if (i == 18) return '1;
      return AW'(1) << (i - 1);
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      chk(req_ready, "R3 ready before write", 32'(req_ready), 1);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
      for (int i = 0; i < E_WP; i++) begin
         chk(!sram_we_n && sram_oe_n && !sram_cs_n && sram_cs && sram_dq_oe && !req_ready,
             "R7 write pulse pins", {27'd0, sram_we_n, sram_oe_n, sram_cs_n, sram_dq_oe, req_ready}, 32'h0A);
         chk(sram_addr == a && sram_dq_out == d, "R9 write addr/data held",
             {7'd0, sram_addr, sram_dq_out}, {7'd0, a, d});
         @(negedge clk);
      end
      for (int i = 0; i < E_WR; i++) begin
         chk(sram_we_n && sram_oe_n && !sram_cs_n && sram_cs && sram_dq_oe && !req_ready,
             "R7 write recovery pins", {27'd0, sram_we_n, sram_oe_n, sram_cs_n, sram_dq_oe, req_ready}, 32'h1A);
         @(negedge clk);
      end
      chk(req_ready, "R8 write busy length", 32'(req_ready), 1);
   endtask

   task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] e);
      chk(req_ready, "R3 ready before read", 32'(req_ready), 1);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0; req_addr = ~a; req_write = 1'b1;
      for (int i = 0; i < E_RD; i++) begin
         chk(!sram_cs_n && sram_cs && !sram_oe_n && sram_we_n && !sram_dq_oe && !req_ready,
             "R4 read pins", {27'd0, sram_we_n, sram_oe_n, sram_cs_n, sram_dq_oe, req_ready}, 32'h10);
         chk(sram_addr == a, "R9 read addr held", 32'(sram_addr), 32'(a));
         @(negedge clk);
      end
      chk(rsp_valid && rsp_rdata == e, "R5 read data", {23'd0, rsp_valid, rsp_rdata}, {23'd1, e});
      for (int i = 0; i < E_HZ; i++) begin
         chk(sram_oe_n && !sram_dq_oe && sram_cs_n && !req_ready, "R6 turnaround",
             {28'd0, sram_oe_n, sram_dq_oe, sram_cs_n, req_ready}, 32'hA);
         if (i == 1) chk(!rsp_valid, "R5 single strobe", 32'(rsp_valid), 0);
         @(negedge clk);
      end
      chk(req_ready, "R8 read busy length", 32'(req_ready), 1);
   endtask

   initial begin
      #800000;
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual hang expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!req_ready && sram_cs_n && !sram_cs && sram_we_n, "R1 reset state",
          {29'd0, req_ready, sram_cs_n, sram_we_n}, 32'h3);
      rst_n = 1'b1;
      // hold a write request during the wait; it must not start
      req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h1_2345; req_wdata = 8'h77;
      for (int k = 0; k <= E_PWR; k++) begin
         if (k == E_PWR - 1) begin
            chk(!req_ready && sram_we_n, "R1 ready low until wait ends",
                {30'd0, req_ready, sram_we_n}, 32'h1);
            chk(sram_we_n, "R3 no write during wait", 32'(sram_we_n), 1);
            req_valid = 1'b0;
         end
         if (k == E_PWR)
            chk(req_ready, "R1 ready after wait", 32'(req_ready), 1);
         if (k < E_PWR - 1 && (req_ready || !sram_we_n))
            chk(0, "R1 early ready or write", {30'd0, req_ready, sram_we_n}, 32'h1);
         @(negedge clk);
      end
      // valid low: nothing accepted
      repeat (2) @(negedge clk);
      chk(req_ready && sram_cs_n && !sram_cs && sram_oe_n && sram_we_n && !sram_dq_oe,
          "R2 idle pins", {27'd0, req_ready, sram_cs_n, sram_oe_n, sram_we_n, sram_dq_oe}, 32'h1E);
      chk(req_ready, "R3 no accept without valid", 32'(req_ready), 1);

      for (int i = 0; i < 19; i++) do_write(sweep_addr(i), pat(sweep_addr(i)));
      for (int i = 18; i >= 0; i--) do_read(sweep_addr(i), pat(sweep_addr(i)));

      // back-to-back write then read on the same address
      for (int i = 0; i < 4; i++) begin
         logic [AW-1:0] a;
         a = AW'(17'h0_F0F0 + 17'(i * 4099));
         do_write(a, 8'(i * 37 + 11));
         do_read(a, 8'(i * 37 + 11));
      end
      chk(req_ready && sram_cs_n && sram_we_n && !sram_dq_oe, "R2 idle after traffic",
          {28'd0, req_ready, sram_cs_n, sram_we_n, sram_dq_oe}, 32'hE);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule